// File: doc/BRIEF.md
# Self-restarting byte move sequencer

This block is the micro-sequencer behind a memory-to-memory move instruction in a compact 8-bit processor. Each time the instruction runs it copies one byte and then restarts itself. The instruction has three bytes: a prefix, an opcode and a zero-page operand. The low source address byte is the X register and the low destination address byte is the Y register. The two high address bytes sit in the zero-page byte named by the operand (source) and in the byte after it (destination). The Z register holds the count of bytes still to move.

On each run the sequencer fetches the three instruction bytes, reads the source high byte, reads the data byte, reads the destination high byte and writes the data byte. When X or Y wraps past the end of a page, the incremented high byte goes back into zero-page memory. No internal register holds it. While Z is still nonzero, the PC is moved back to the prefix byte. This makes the interrupt boundary fall between bytes, and a resumed move re-enters cleanly at the prefix.

The surrounding core starts the sequencer with a one-cycle request that carries PC, X, Y and Z. It reads the updated values back once the sequencer is idle again. The memory port is asynchronous: the read data is used in the same cycle as the address, and a write takes effect at the clock edge that ends its cycle.

Top module: `byte_move_seq`

## Requirements
- R1: After reset the sequencer is idle, with `idle`=1 and `memWe`=0, and `pcOut`, `xOut`, `yOut` and `zOut` are all zero. While idle it never writes memory.
- R2: A start request loads PC, X, Y and Z. Each run of the instruction then begins with three fetch cycles, at addresses PC, PC+1 and PC+2, and none of them writes. The third fetch latches the zero-page operand.
- R3: In the 4th cycle of a run the sequencer reads zero-page address {0x00, operand}, which gives the source high byte. In the 5th cycle it reads the data byte at {source high, X}, and X increments at the end of that cycle.
- R4: If X was 0xFF in the data-read cycle, one extra cycle follows. That cycle writes source high + 1 to {0x00, operand}.
- R5: The next cycle reads {0x00, operand+1}, which gives the destination high byte. The cycle after that writes the data byte to {destination high, Y}. Y increments and Z decrements (modulo 256) at the end of the write cycle.
- R6: If Y was 0xFF in the write cycle, one extra cycle follows. That cycle writes destination high + 1 to {0x00, operand+1}.
- R7: If Z is nonzero after the decrement, the PC returns to the prefix address. With no interrupt request, the next cycle fetches the prefix again.
- R8: If Z is zero after the decrement, the PC ends at prefix address + 3 and the sequencer goes idle.
- R9: `irqReq` is sampled only in the last cycle of a run. If it is high there and Z is still nonzero, the sequencer goes idle with PC at the prefix address and X, Y and Z covering every byte moved so far. A new start with those values completes the move exactly as an uninterrupted move would.
- R10: operand+1 wraps within page zero, so an operand of 0xFF takes the destination high byte from address 0x0000.
- R11: A start with Z=0 moves 256 bytes.
- R12: A run lasts 7 cycles, plus one cycle for each page wrap of X or Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle start pulse, taken only while idle |
| pcIn | input | 16 | Prefix address loaded at start |
| xIn | input | 8 | Source low byte loaded at start |
| yIn | input | 8 | Destination low byte loaded at start |
| zIn | input | 8 | Byte count loaded at start (0 means 256) |
| irqReq | input | 1 | Interrupt request, sampled in the last cycle of a run |
| memRdata | input | 8 | Read data for the current address |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Write data |
| memWe | output | 1 | Write enable |
| idle | output | 1 | Sequencer idle; the register outputs are final |
| pcOut | output | 16 | Current PC |
| xOut | output | 8 | Current X |
| yOut | output | 8 | Current Y |
| zOut | output | 8 | Current Z |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 16-bit address and a 3-byte instruction. At these values a single-page move of up to 256 bytes can be simulated in full. Cases where X and Y start just below a page boundary bring both write-back cycles into reach. Operand 0xFF exercises the zero-page wrap. Random placements let the destination or the write-backs overwrite the instruction bytes, the operand or the high bytes themselves, and the bench's reference re-reads all of them on every run.

// File: rtl/bms_pkg.sv
package bms_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;
  localparam int INSN_LEN = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_OPC, ST_OPR, ST_SRCH, ST_RDAT,
    ST_CSRC, ST_DSTH, ST_WDAT, ST_CDST
  } stateT;

  typedef enum logic [2:0] {A_PC, A_ZP0, A_ZP1, A_SRC, A_DST} addrSelT;

  typedef struct packed {
    logic    load;
    logic    pcInc;
    logic    rewind;
    logic    latchOpr;
    logic    latchHi;
    logic    latchData;
    logic    incX;
    logic    incY;
    logic    decZ;
    logic    we;
    logic    wrHi;
    addrSelT aSel;
  } strobeT;
endpackage

// File: rtl/bms_dp.sv
module bms_dp
  import bms_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ILEN = INSN_LEN
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                stb,
  input  logic [2*DATA_W-1:0]   pcIn,
  input  logic [DATA_W-1:0]     xIn,
  input  logic [DATA_W-1:0]     yIn,
  input  logic [DATA_W-1:0]     zIn,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]     memWdata,
  output logic                  memWe,
  output logic [2*DATA_W-1:0]   pcOut,
  output logic [DATA_W-1:0]     xOut,
  output logic [DATA_W-1:0]     yOut,
  output logic [DATA_W-1:0]     zOut,
  output logic                  xWrap,
  output logic                  yWrap,
  output logic                  zIsOne,
  output logic                  zIsZero
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(ILEN);
  localparam logic [DATA_W-1:0] PAGE_ZERO = '0;

  logic [ADDR_W-1:0] pcR;
  logic [DATA_W-1:0] oprR, hiR, datR, xR, yR, zR;
  logic [DATA_W-1:0] oprNext;

  assign oprNext = oprR + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR  <= '0;
      oprR <= '0;
      hiR  <= '0;
      datR <= '0;
      xR   <= '0;
      yR   <= '0;
      zR   <= '0;
    end else if (stb.load) begin
      pcR <= pcIn;
      xR  <= xIn;
      yR  <= yIn;
      zR  <= zIn;
    end else begin
      if (stb.pcInc)     pcR  <= pcR + 1'b1;
      if (stb.rewind)    pcR  <= pcR - PC_STEP;
      if (stb.latchOpr)  oprR <= memRdata;
      if (stb.latchHi)   hiR  <= memRdata;
      if (stb.latchData) datR <= memRdata;
      if (stb.incX)      xR   <= xR + 1'b1;
      if (stb.incY)      yR   <= yR + 1'b1;
      if (stb.decZ)      zR   <= zR - 1'b1;
    end
  end

  always_comb begin
    case (stb.aSel)
      A_ZP0:   memAddr = {PAGE_ZERO, oprR};
      A_ZP1:   memAddr = {PAGE_ZERO, oprNext};
      A_SRC:   memAddr = {hiR, xR};
      A_DST:   memAddr = {hiR, yR};
      default: memAddr = pcR;
    endcase
  end

  assign memWdata = stb.wrHi ? hiR + 1'b1 : datR;
  assign memWe    = stb.we;

  assign pcOut   = pcR;
  assign xOut    = xR;
  assign yOut    = yR;
  assign zOut    = zR;
  assign xWrap   = &xR;
  assign yWrap   = &yR;
  assign zIsOne  = (zR == DATA_W'(1));
  assign zIsZero = (zR == '0);
endmodule

// File: rtl/bms_ctl.sv
module bms_ctl
  import bms_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   irqReq,
  input  logic   xWrap,
  input  logic   yWrap,
  input  logic   zIsOne,
  input  logic   zIsZero,
  output strobeT stb,
  output stateT  state
);
  stateT nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    stb.aSel  = A_PC;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.load  = 1'b1;
          nextState = ST_PRE;
        end
      end
      ST_PRE: begin
        stb.pcInc = 1'b1;
        nextState = ST_OPC;
      end
      ST_OPC: begin
        stb.pcInc = 1'b1;
        nextState = ST_OPR;
      end
      ST_OPR: begin
        stb.pcInc    = 1'b1;
        stb.latchOpr = 1'b1;
        nextState    = ST_SRCH;
      end
      ST_SRCH: begin
        stb.aSel    = A_ZP0;
        stb.latchHi = 1'b1;
        nextState   = ST_RDAT;
      end
      ST_RDAT: begin
        stb.aSel      = A_SRC;
        stb.latchData = 1'b1;
        stb.incX      = 1'b1;
        nextState     = xWrap ? ST_CSRC : ST_DSTH;
      end
      ST_CSRC: begin
        stb.aSel  = A_ZP0;
        stb.we    = 1'b1;
        stb.wrHi  = 1'b1;
        nextState = ST_DSTH;
      end
      ST_DSTH: begin
        stb.aSel    = A_ZP1;
        stb.latchHi = 1'b1;
        nextState   = ST_WDAT;
      end
      ST_WDAT: begin
        stb.aSel = A_DST;
        stb.we   = 1'b1;
        stb.incY = 1'b1;
        stb.decZ = 1'b1;
        if (yWrap) nextState = ST_CDST;
        else begin
          stb.rewind = !zIsOne;
          nextState  = (zIsOne || irqReq) ? ST_IDLE : ST_PRE;
        end
      end
      ST_CDST: begin
        stb.aSel   = A_ZP1;
        stb.we     = 1'b1;
        stb.wrHi   = 1'b1;
        stb.rewind = !zIsZero;
        nextState  = (zIsZero || irqReq) ? ST_IDLE : ST_PRE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/byte_move_seq.sv
module byte_move_seq
  import bms_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic [AW-1:0] pcIn,
  input  logic [DW-1:0] xIn,
  input  logic [DW-1:0] yIn,
  input  logic [DW-1:0] zIn,
  input  logic          irqReq,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic          idle,
  output logic [AW-1:0] pcOut,
  output logic [DW-1:0] xOut,
  output logic [DW-1:0] yOut,
  output logic [DW-1:0] zOut
);
  strobeT stb;
  stateT  curState;
  logic   xWrap, yWrap, zIsOne, zIsZero;

  bms_ctl u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .irqReq(irqReq),
    .xWrap(xWrap), .yWrap(yWrap), .zIsOne(zIsOne), .zIsZero(zIsZero),
    .stb(stb), .state(curState)
  );

  bms_dp #(.DATA_W(DW), .ILEN(INSN_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pcIn(pcIn), .xIn(xIn),
    .yIn(yIn), .zIn(zIn), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .pcOut(pcOut), .xOut(xOut),
    .yOut(yOut), .zOut(zOut), .xWrap(xWrap), .yWrap(yWrap),
    .zIsOne(zIsOne), .zIsZero(zIsZero)
  );

  assign idle = (curState == ST_IDLE);
endmodule

// File: rtl/byte_move_seq_chk.sv
module byte_move_seq_chk
  import bms_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input stateT         st,
  input logic          idle,
  input logic [AW-1:0] memAddr,
  input logic          memWe,
  input logic [AW-1:0] pcOut,
  input logic [DW-1:0] xOut,
  input logic [DW-1:0] zOut
);
  localparam logic [AW-1:0] STEP = AW'(INSN_LEN);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !memWe);

  p_fetch_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PRE || st == ST_OPC || st == ST_OPR) |-> !memWe);

  p_x_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RDAT) |=> (xOut == $past(xOut) + 1'b1));

  p_src_carry_zp_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CSRC) |-> (memWe && memAddr[AW-1:DW] == '0));

  p_z_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WDAT) |=> (zOut == $past(zOut) - 1'b1));

  p_dst_carry_zp_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CDST) |-> (memWe && memAddr[AW-1:DW] == '0));

  p_rewind_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PRE && $past(st) != ST_IDLE) |-> (memAddr == $past(pcOut) - STEP));
endmodule

bind byte_move_seq byte_move_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .st(curState), .idle(idle), .memAddr(memAddr),
  .memWe(memWe), .pcOut(pcOut), .xOut(xOut), .zOut(zOut)
);

// File: tb/byte_move_seq_bench.sv
module byte_move_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  xIn = '0, yIn = '0, zIn = '0;
  logic        irqReq = 1'b0;
  logic [7:0]  memRdata;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe, idle;
  logic [15:0] pcOut;
  logic [7:0]  xOut, yOut, zOut;

  int checks = 0;
  int fails = 0;

  logic [7:0] mem [logic [15:0]];
  logic [7:0] refMem [logic [15:0]];

  always #10 clk = ~clk;

  byte_move_seq u_byte_move_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pcIn(pcIn), .xIn(xIn),
    .yIn(yIn), .zIn(zIn), .irqReq(irqReq), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .idle(idle),
    .pcOut(pcOut), .xOut(xOut), .yOut(yOut), .zOut(zOut)
  );

  function automatic logic [7:0] dflt(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] memRd(logic [15:0] a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction
  function automatic logic [7:0] refRd(logic [15:0] a);
    return refMem.exists(a) ? refMem[a] : dflt(a);
  endfunction

  always @(memAddr or negedge clk) begin
    if (clk == 1'b0 && memWe && rstN) mem[memAddr] = memWdata;
    memRdata = memRd(memAddr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [15:0] rPc;
  logic [7:0]  rX, rY, rZ;

  task automatic refRun(input bit irq, output int cyc, output int firstLen,
                        output int iters);
    logic [7:0] opr, shi, dhi, d;
    cyc = 0; firstLen = 0; iters = 0;
    forever begin
      opr = refRd(rPc + 16'd2);
      shi = refRd({8'h00, opr});
      d   = refRd({shi, rX});
      cyc += 7;
      rX = rX + 8'd1;
      if (rX == 8'd0) begin refMem[{8'h00, opr}] = shi + 8'd1; cyc++; end
      dhi = refRd({8'h00, opr + 8'd1});
      refMem[{dhi, rY}] = d;
      rY = rY + 8'd1;
      rZ = rZ - 8'd1;
      if (rY == 8'd0) begin refMem[{8'h00, opr + 8'd1}] = dhi + 8'd1; cyc++; end
      iters++;
      if (iters == 1) firstLen = cyc;
      if (rZ == 8'd0) begin rPc = rPc + 16'd3; break; end
      if (irq) break;
    end
  endtask

  task automatic execute(input logic [15:0] p, input logic [7:0] x,
                         input logic [7:0] y, input logic [7:0] z, input bit irq,
                         input string tag);
    int expCyc, firstLen, iters, cyc;
    rPc = p; rX = x; rY = y; rZ = z;
    refRun(irq, expCyc, firstLen, iters);
    @(negedge clk);
    startReq = 1'b1; pcIn = p; xIn = x; yIn = y; zIn = z; irqReq = irq;
    @(negedge clk);
    startReq = 1'b0;
    cyc = 0;
    while (idle == 1'b0 && cyc < 5000) begin
      if (cyc < 3)
        chk(memAddr == p + 16'(cyc) && !memWe, "R2", {tag, " fetch addr"},
            memAddr, p + 16'(cyc));
      if (iters > 1 && cyc == firstLen)
        chk(memAddr == p, "R7", {tag, " refetch prefix"}, memAddr, p);
      cyc++;
      @(negedge clk);
    end
    chk(cyc == expCyc, "R12", {tag, " cycle count"}, cyc, expCyc);
    chk(pcOut == rPc, rZ == 0 ? "R8" : "R9", {tag, " pc"}, pcOut, rPc);
    chk(xOut == rX && yOut == rY, "R3/R5", {tag, " x,y"}, {xOut, yOut}, {rX, rY});
    chk(zOut == rZ, "R5", {tag, " z"}, zOut, rZ);
  endtask

  task automatic putBoth(input logic [15:0] a, input logic [7:0] v);
    mem[a] = v;
    refMem[a] = v;
  endtask

  task automatic runMove(input logic [15:0] p, input logic [7:0] opr,
                         input logic [7:0] sHi, input logic [7:0] dHi,
                         input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] z, input bit irq, input string tag);
    bit ok;
    mem.delete(); refMem.delete();
    putBoth(p, 8'hC2); putBoth(p + 16'd1, 8'h54); putBoth(p + 16'd2, opr);
    putBoth({8'h00, opr}, sHi); putBoth({8'h00, opr + 8'd1}, dHi);
    execute(p, x, y, z, irq, tag);
    if (irq && zOut != 8'd0) begin
      chk(pcOut == p, "R9", {tag, " paused at prefix"}, pcOut, p);
      execute(pcOut, xOut, yOut, zOut, 1'b0, {tag, " resume"});
    end
    ok = 1'b1;
    foreach (mem[k]) if (mem[k] != refRd(k)) ok = 1'b0;
    foreach (refMem[k]) if (memRd(k) != refMem[k]) ok = 1'b0;
    chk(ok, "R3/R4/R5/R6", {tag, " memory image"}, ok, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(idle && !memWe, "R1", "reset idle", {idle, memWe}, 2);
    chk(pcOut == 0 && xOut == 0 && yOut == 0 && zOut == 0, "R1", "reset regs",
        pcOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(idle && !memWe, "R1", "idle after release", {idle, memWe}, 2);

    runMove(16'h0400, 8'h40, 8'h12, 8'h34, 8'h10, 8'h20, 8'd3, 1'b0, "plain");
    runMove(16'h0400, 8'h40, 8'h12, 8'h34, 8'hFE, 8'h20, 8'd4, 1'b0, "R4 xwrap");
    runMove(16'h0400, 8'h40, 8'h12, 8'h34, 8'h10, 8'hFF, 8'd2, 1'b0, "R6 ywrap");
    runMove(16'h0400, 8'hFF, 8'h12, 8'h34, 8'h10, 8'h20, 8'd3, 1'b0, "R10 opr FF");
    runMove(16'h0800, 8'h80, 8'h21, 8'h43, 8'h00, 8'h00, 8'd0, 1'b0, "R11 count 0");
    runMove(16'h0400, 8'h40, 8'h12, 8'h34, 8'h10, 8'h20, 8'd1, 1'b0, "R8 single");
    runMove(16'h0400, 8'h40, 8'h12, 8'h34, 8'hFF, 8'hFF, 8'd5, 1'b1, "R9 irq");
    runMove(16'h0400, 8'h40, 8'h12, 8'h34, 8'h10, 8'h20, 8'd1, 1'b1, "R9 irq last");

    for (int i = 0; i < 12; i++) begin
      logic [7:0] rx, ry;
      rx = ($urandom % 2) ? 8'hF8 + 8'($urandom % 8) : 8'($urandom);
      ry = ($urandom % 2) ? 8'hF8 + 8'($urandom % 8) : 8'($urandom);
      runMove(16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              rx, ry, 8'd1 + 8'($urandom % 24), bit'($urandom % 3 == 0),
              "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule